// File: doc/BRIEF.md
# Dual Quad-SPI Flash Router

This block sits between a quad-SPI serial engine that knows about one flash device and a board that carries two identical flash devices. It turns the engine's single chip select, serial clock and four IO lanes into two device-side pin sets, a lower port and an upper port. Command sequencing, clock generation and any flash protocol handling stay in the engine. The router only steers pins.

Three connection modes are supported. In single mode, only the lower device is wired to the engine. In stacked mode, the two devices share one clock and one 4-lane bus, which is the lower port's clock and IO pins. A page bit then chooses which device's chip select follows the engine, so the two devices are reached one after the other. In parallel mode, each device has its own 4-lane bus and both are selected together. The engine then moves an 8-bit word per IO cycle: even bits travel to the lower device and odd bits to the upper device.

The mode and page come from a configuration word. They are captured only while the engine's chip select is high, so a change made in the middle of a transfer never splits it across devices. All other paths are combinational. There is no back-pressure at any pin: every output follows its inputs in the same cycle. Because both devices are identical, one command stream serves either device.

Top module: `dqf_router`

## Requirements
- R1: Mode decode uses configuration bits 30 (dual enable), 29 (separate buses) and 28 (upper page), as follows.
  - Bit 30 clear gives single mode. Bits 29 and 28 are then ignored.
  - Bit 30 set with bit 29 clear gives stacked mode.
  - Bits 30 and 29 both set give parallel mode.
- R2: In single mode the upper port is idle: `up_cs_n` is high, `up_sclk` is low and `up_io_oe` is 0. Whenever the mode is not parallel, the upper port is idle in this way except for `up_cs_n` (see R4).
- R3: In single and stacked mode, the lower port carries the shared bus, as follows.
  - `lo_io_o` equals `eng_tx[3:0]`.
  - `lo_io_oe` equals `eng_oe`.
  - `lo_sclk` equals `eng_sclk`.
  - `eng_rx[3:0]` equals `lo_io_i`, and `eng_rx[7:4]` is 0.
- R4: In stacked mode, the chip selects depend on the page bit, as follows.
  - Page bit clear: `lo_cs_n` follows `eng_cs_n` and `up_cs_n` stays high.
  - Page bit set: `up_cs_n` follows `eng_cs_n` and `lo_cs_n` stays high.
  - The two selects are never low together.
- R5: In parallel mode, the transmit word is split by bit parity across the two ports. For each lane i, `lo_io_o[i]` is `eng_tx[2i]` and `up_io_o[i]` is `eng_tx[2i+1]`.
- R6: In parallel mode, both chip selects follow `eng_cs_n`. Both `lo_sclk` and `up_sclk` equal `eng_sclk`. `eng_oe` is copied to both `lo_io_oe` and `up_io_oe`.
- R7: In parallel mode, the receive word is rebuilt from both ports. For each lane i, `eng_rx[2i]` is `lo_io_i[i]` and `eng_rx[2i+1]` is `up_io_i[i]`.
- R8: The configuration word is captured at each rising clock edge at which `eng_cs_n` is high. While `eng_cs_n` is low, a configuration change has no effect. It takes hold after the first rising edge that samples `eng_cs_n` high.
- R9: After reset the captured state is single mode, lower page.
- R10: While `eng_cs_n` is high, both `lo_cs_n` and `up_cs_n` are high in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration capture |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 32 | Configuration word; bits 30, 29 and 28 are decoded |
| eng_cs_n | input | 1 | Engine chip select, active low |
| eng_sclk | input | 1 | Engine serial clock |
| eng_tx | input | 8 | Engine transmit lanes; bits 3:0 are used outside parallel mode |
| eng_oe | input | 4 | Engine per-lane output enables |
| eng_rx | output | 8 | Receive lanes to the engine |
| lo_cs_n | output | 1 | Lower device chip select |
| lo_sclk | output | 1 | Lower (or shared) clock |
| lo_io_o | output | 4 | Lower (or shared) bus output data |
| lo_io_oe | output | 4 | Lower (or shared) bus output enables |
| lo_io_i | input | 4 | Lower (or shared) bus input data |
| up_cs_n | output | 1 | Upper device chip select |
| up_sclk | output | 1 | Upper device clock (parallel mode only) |
| up_io_o | output | 4 | Upper bus output data |
| up_io_oe | output | 4 | Upper bus output enables |
| up_io_i | input | 4 | Upper bus input data |

## Verification
The captured mode and page are the only state in the block. A wrong value shows up in the same cycle as a wrong chip select or a wrong lane mapping: a swapped page selects the other device, and a lost parallel mode zeroes `eng_rx[7:4]` and idles the upper clock. The bench sweeps every combination of the three decoded configuration bits against all 256 transmit patterns and receive nibble pairs. It also changes the configuration in the middle of a transfer, to show that the old selection holds until the first edge with the chip select high.

// File: rtl/dqf_pkg.sv
package dqf_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'd0,
    MODE_STACKED  = 2'd1,
    MODE_PARALLEL = 2'd2
  } dqf_mode_e;
endpackage

// File: rtl/dqf_mode_latch.sv
module dqf_mode_latch
  import dqf_pkg::*;
#(
  parameter int CFG_W    = 32,
  parameter int DUAL_BIT = 30,
  parameter int SEP_BIT  = 29,
  parameter int PAGE_BIT = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eng_cs_n,
  input  logic [CFG_W-1:0] cfg_word,
  output dqf_mode_e        mode_q,
  output logic             upper_q
);
  dqf_mode_e mode_d;

  always_comb begin
    if (!cfg_word[DUAL_BIT])    mode_d = MODE_SINGLE;
    else if (cfg_word[SEP_BIT]) mode_d = MODE_PARALLEL;
    else                        mode_d = MODE_STACKED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_SINGLE;
      upper_q <= 1'b0;
    end else if (eng_cs_n) begin
      mode_q  <= mode_d;
      upper_q <= cfg_word[PAGE_BIT] & cfg_word[DUAL_BIT];
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_cs_n |=> $stable(mode_q) && $stable(upper_q)); // R8
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'd3); // R1
endmodule

// File: rtl/dqf_select.sv
module dqf_select
  import dqf_pkg::*;
(
  input  dqf_mode_e mode,
  input  logic      upper,
  input  logic      eng_cs_n,
  input  logic      eng_sclk,
  output logic      lo_cs_n,
  output logic      up_cs_n,
  output logic      lo_sclk,
  output logic      up_sclk
);
  logic par, stk;
  logic lo_en, up_en;

  always_comb begin
    par     = (mode == MODE_PARALLEL);
    stk     = (mode == MODE_STACKED);
    lo_en   = par | (mode == MODE_SINGLE) | (stk & ~upper);
    up_en   = par | (stk & upper);
    lo_cs_n = eng_cs_n | ~lo_en;
    up_cs_n = eng_cs_n | ~up_en;
    lo_sclk = eng_sclk;
    up_sclk = par & eng_sclk;
  end

  always_comb begin
    AST_ONE_CS_STACKED: assert (!stk || lo_cs_n || up_cs_n); // R4
    AST_IDLE_CS: assert (!eng_cs_n || (lo_cs_n && up_cs_n)); // R10
  end
endmodule

// File: rtl/dqf_lane_mux.sv
module dqf_lane_mux
  import dqf_pkg::*;
#(
  parameter int LANES = 4
) (
  input  dqf_mode_e          mode,
  input  logic [2*LANES-1:0] eng_tx,
  input  logic [LANES-1:0]   eng_oe,
  output logic [2*LANES-1:0] eng_rx,
  output logic [LANES-1:0]   lo_io_o,
  output logic [LANES-1:0]   lo_io_oe,
  input  logic [LANES-1:0]   lo_io_i,
  output logic [LANES-1:0]   up_io_o,
  output logic [LANES-1:0]   up_io_oe,
  input  logic [LANES-1:0]   up_io_i
);
  localparam int WORD_W = 2 * LANES;

  logic               par;
  logic [LANES-1:0]   tx_even, tx_odd;
  logic [WORD_W-1:0]  rx_woven;

  assign par = (mode == MODE_PARALLEL);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign tx_even[i]       = eng_tx[2*i];
    assign tx_odd[i]        = eng_tx[2*i+1];
    assign rx_woven[2*i]    = lo_io_i[i];
    assign rx_woven[2*i+1]  = up_io_i[i];
  end

  always_comb begin
    if (par) begin
      lo_io_o  = tx_even;
      up_io_o  = tx_odd;
      up_io_oe = eng_oe;
      eng_rx   = rx_woven;
    end else begin
      lo_io_o  = eng_tx[LANES-1:0];
      up_io_o  = '0;
      up_io_oe = '0;
      eng_rx   = {{LANES{1'b0}}, lo_io_i};
    end
    lo_io_oe = eng_oe;
  end

  always_comb begin
    AST_UP_QUIET: assert (par || (up_io_oe == '0)); // R2
    AST_OE_COPY: assert (!par || (lo_io_oe == up_io_oe)); // R6
  end
endmodule

// File: rtl/dqf_router.sv
module dqf_router
  import dqf_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int CFG_W    = 32,
  parameter int DUAL_BIT = 30,
  parameter int SEP_BIT  = 29,
  parameter int PAGE_BIT = 28
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CFG_W-1:0]   cfg_word,
  input  logic               eng_cs_n,
  input  logic               eng_sclk,
  input  logic [2*LANES-1:0] eng_tx,
  input  logic [LANES-1:0]   eng_oe,
  output logic [2*LANES-1:0] eng_rx,
  output logic               lo_cs_n,
  output logic               lo_sclk,
  output logic [LANES-1:0]   lo_io_o,
  output logic [LANES-1:0]   lo_io_oe,
  input  logic [LANES-1:0]   lo_io_i,
  output logic               up_cs_n,
  output logic               up_sclk,
  output logic [LANES-1:0]   up_io_o,
  output logic [LANES-1:0]   up_io_oe,
  input  logic [LANES-1:0]   up_io_i
);
  dqf_mode_e mode;
  logic      upper;

  dqf_mode_latch #(
    .CFG_W(CFG_W), .DUAL_BIT(DUAL_BIT), .SEP_BIT(SEP_BIT), .PAGE_BIT(PAGE_BIT)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .eng_cs_n(eng_cs_n), .cfg_word(cfg_word),
    .mode_q(mode), .upper_q(upper)
  );

  dqf_select u_sel (
    .mode(mode), .upper(upper), .eng_cs_n(eng_cs_n), .eng_sclk(eng_sclk),
    .lo_cs_n(lo_cs_n), .up_cs_n(up_cs_n), .lo_sclk(lo_sclk), .up_sclk(up_sclk)
  );

  dqf_lane_mux #(.LANES(LANES)) u_mux (
    .mode(mode), .eng_tx(eng_tx), .eng_oe(eng_oe), .eng_rx(eng_rx),
    .lo_io_o(lo_io_o), .lo_io_oe(lo_io_oe), .lo_io_i(lo_io_i),
    .up_io_o(up_io_o), .up_io_oe(up_io_oe), .up_io_i(up_io_i)
  );

  AST_SINGLE_UP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SINGLE) |-> (up_cs_n && !up_sclk)); // R2
  AST_PAR_LOCKSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PARALLEL) |-> (up_sclk == lo_sclk && up_cs_n == lo_cs_n)); // R6
endmodule

// File: tb/dqf_router_tb.sv
module dqf_router_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_word;
  logic        eng_cs_n, eng_sclk;
  logic [7:0]  eng_tx;
  logic [3:0]  eng_oe;
  logic [7:0]  eng_rx;
  logic        lo_cs_n, lo_sclk, up_cs_n, up_sclk;
  logic [3:0]  lo_io_o, lo_io_oe, lo_io_i, up_io_o, up_io_oe, up_io_i;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  dqf_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .eng_cs_n(eng_cs_n),
    .eng_sclk(eng_sclk), .eng_tx(eng_tx), .eng_oe(eng_oe), .eng_rx(eng_rx),
    .lo_cs_n(lo_cs_n), .lo_sclk(lo_sclk), .lo_io_o(lo_io_o), .lo_io_oe(lo_io_oe),
    .lo_io_i(lo_io_i), .up_cs_n(up_cs_n), .up_sclk(up_sclk), .up_io_o(up_io_o),
    .up_io_oe(up_io_oe), .up_io_i(up_io_i)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_cfg(logic dual, logic sep, logic page);
    @(negedge clk);
    eng_cs_n = 1'b1;
    cfg_word = 32'h0F0F_00A5;
    cfg_word[30] = dual; cfg_word[29] = sep; cfg_word[28] = page;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] pick(logic [7:0] w, int ofs);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = w[2*i+ofs];
    return r;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_word = 32'h7000_0000; eng_cs_n = 1'b0; eng_sclk = 1'b1;
    eng_tx = 8'hFF; eng_oe = 4'hF; lo_io_i = 4'h5; up_io_i = 4'hA;
    repeat (2) @(posedge clk);
    #1;
    // R9: reset leaves single mode, lower page
    chk("R9 lo_cs_n", lo_cs_n, 0);
    chk("R9 up_cs_n", up_cs_n, 1);
    chk("R9 up_sclk", up_sclk, 0);
    chk("R9 eng_rx", eng_rx, 8'h05);
    @(negedge clk); rst_n = 1'b1;

    for (int m = 0; m < 8; m++) begin
      logic dual, sep, page, par, stk;
      dual = m[2]; sep = m[1]; page = m[0];
      par = dual & sep; stk = dual & ~sep;
      set_cfg(dual, sep, page);
      // R10: deselected engine leaves both devices deselected
      chk("R10 lo_cs_n", lo_cs_n, 1);
      chk("R10 up_cs_n", up_cs_n, 1);
      eng_cs_n = 1'b0;
      for (int t = 0; t < 256; t++) begin
        logic [7:0] w;
        w = t[7:0];
        eng_tx = w; eng_oe = w[3:0] ^ 4'hA; eng_sclk = w[0];
        lo_io_i = w[3:0]; up_io_i = w[7:4];
        #1;
        if (par) begin
          chk("R5 lo_io_o", lo_io_o, pick(w, 0));
          chk("R5 up_io_o", up_io_o, pick(w, 1));
          chk("R6 up_io_oe", up_io_oe, w[3:0] ^ 4'hA);
          chk("R6 up_sclk", up_sclk, w[0]);
          chk("R6 cs", {lo_cs_n, up_cs_n}, 2'b00);
          begin
            logic [7:0] e;
            for (int i = 0; i < 4; i++) begin e[2*i] = w[i]; e[2*i+1] = w[4+i]; end
            chk("R7 eng_rx", eng_rx, e);
          end
        end else begin
          chk("R3 lo_io_o", lo_io_o, w[3:0]);
          chk("R3 eng_rx", eng_rx, {4'h0, w[3:0]});
          chk("R2 up_io_oe", up_io_oe, 0);
          chk("R2 up_sclk", up_sclk, 0);
          if (stk) begin
            chk("R4 lo_cs_n", lo_cs_n, page);
            chk("R4 up_cs_n", up_cs_n, !page);
          end else begin
            // R1: bits 29 and 28 ignored without bit 30
            chk("R1 cs", {lo_cs_n, up_cs_n}, 2'b01);
          end
        end
        chk("R3 lo_io_oe", lo_io_oe, w[3:0] ^ 4'hA);
        chk("R3 lo_sclk", lo_sclk, w[0]);
        #1;
      end
    end

    // R8: stacked lower selected, switch to upper page mid-transfer
    set_cfg(1'b1, 1'b0, 1'b0);
    eng_cs_n = 1'b0;
    cfg_word[28] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 held lo_cs_n", lo_cs_n, 0);
    chk("R8 held up_cs_n", up_cs_n, 1);
    cfg_word[29] = 1'b1;
    @(negedge clk);
    chk("R8 held mode", {up_sclk, eng_rx[7:4]}, 5'h0);
    eng_cs_n = 1'b1;
    @(posedge clk); @(negedge clk);
    cfg_word = 32'h5000_0000;   // stacked, upper page
    eng_cs_n = 1'b1;
    @(posedge clk); @(negedge clk);
    eng_cs_n = 1'b0;
    #1;
    chk("R8 applied lo_cs_n", lo_cs_n, 1);
    chk("R8 applied up_cs_n", up_cs_n, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule